// File: doc/BRIEF.md
# Reset Cause Controller

This block gathers four independent reasons for restarting the chip into a single system reset and keeps a record of which reason caused the latest restart. The four reasons are an out-of-range reference clock reported by a frequency monitor, a PLL that drops out of lock, modules that fail to acknowledge a stop-mode request in time, and a software request. Each reason passes its own qualifying gate before it can trigger anything. The clock monitor needs its enable. The lock detector must be armed and must not be in stop. The stop watchdog measures time in edges of a slow low-power tick.

Every qualified request starts or extends a system reset, which is held for a fixed number of clock cycles. A separate debug-domain reset follows the system reset for the hardware reasons and for power-on. It stays low for a software request, so a debugger attached to the chip survives a software restart. Four sticky cause flags hold the reasons seen in the cycle the reset began, and software reads them after the restart.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A clock-loss request is raised only while `clkMonEn` is 1 and the selected range's slow or fast indicator is high after a two-stage synchronizer. An input pulse sampled at clock edge n starts the reset at edge n+2.
- R2: `rangeSel` chooses which bit of `refSlow`/`refFast` is used. Pulses on the indicators of any range that is not selected cause no reset.
- R3: Lock-loss detection is armed only while `pllEngagedExt` is 1 and after `pllLocked` has been seen high in that mode. Once armed, `pllLocked` low with `lolResetEn` 1 raises a request. Leaving the engaged mode disarms the detector.
- R4: While `inStop` is 1, lock loss raises no request.
- R5: While `stopReq` is 1 and not every bit of `stopAck` is 1, the 1025th rising edge of `lpoTick` raises a request. The 1024th rising edge does not.
- R6: The stop-acknowledge tick count returns to zero whenever `stopReq` is 0 or all `stopAck` bits are 1. It counts only rising edges of `lpoTick`.
- R7: A software request (`swResetReq` high at an edge) asserts `sysReset` and leaves `dbgReset` at 0 throughout.
- R8: Clock-loss, lock-loss and stop-timeout requests assert `dbgReset` together with `sysReset`. `dbgReset` is never 1 while `sysReset` is 0.
- R9: At the edge where `sysReset` rises, the flags `locFlag`, `lolFlag`, `sackFlag` and `swFlag` each take the value of their own source in that cycle. Flags from earlier resets are cleared at that edge. Requests that arrive during an ongoing reset leave the flags unchanged. The flags stay unchanged after release.
- R10: Any request sampled at an edge keeps `sysReset` at 1 through the following 16 edges; it falls at the 16th edge after the last request. Release is synchronous to `clk`.
- R11: While `rstN` is 0, `sysReset` and `dbgReset` are 1 and all flags are 0. After `rstN` rises, both resets fall at the 16th clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| clkMonEn | input | 1 | Clock monitor enable |
| rangeSel | input | RSEL_W | Selects the active frequency-limit range |
| refSlow | input | NUM_RANGES | Per-range pulse: reference below the lower limit |
| refFast | input | NUM_RANGES | Per-range pulse: reference above the upper limit |
| pllEngagedExt | input | 1 | Clock generator runs in PLL-engaged-external mode |
| pllLocked | input | 1 | PLL lock indication |
| lolResetEn | input | 1 | Lock-loss reset enable |
| inStop | input | 1 | Chip is in a stop mode |
| stopReq | input | 1 | Stop-mode entry requested |
| stopAck | input | NUM_ACK | Per-module stop acknowledge |
| lpoTick | input | 1 | Low-power 1 kHz tick level |
| swResetReq | input | 1 | Software reset request |
| sysReset | output | 1 | System reset, active high |
| dbgReset | output | 1 | Debug-domain reset, active high |
| locFlag | output | 1 | Cause flag: clock loss |
| lolFlag | output | 1 | Cause flag: lock loss |
| sackFlag | output | 1 | Cause flag: stop acknowledge timeout |
| swFlag | output | 1 | Cause flag: software request |

## Verification
The hardest condition to reach is the stop-acknowledge timeout on exactly its 1025th slow tick. The stimulus drives 1024 tick pulses and confirms that no reset appears. Only then is the final pulse applied. A second run interrupts the count with a full acknowledge, then drives more than 1025 ticks in total across the interruption and confirms that the count started over. A single-cycle software request is placed in the exact cycle where a synchronized clock-loss pulse emerges. This produces a two-cause capture, and the dual flag and the debug reset rule are checked in that same episode.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  // one bit per reset cause; loc is bit 0
  typedef struct packed {
    logic sw;
    logic sack;
    logic lol;
    logic loc;
  } srcVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadHold;
    logic    capture;
    logic    dbgJoin;
    srcVec_t src;
  } ctlStrb_t;
endpackage

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
  import rst_cause_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     clkMonEn,
  input  logic     pllEngagedExt,
  input  logic     pllLocked,
  input  logic     lolResetEn,
  input  logic     inStop,
  input  logic     swResetReq,
  input  logic     locHit,
  input  logic     sackHit,
  input  logic     sysReset,
  output ctlStrb_t strb
);
  logic    lolArmed;
  srcVec_t src;
  logic    anyReq;

  // arming: lock must be seen once in engaged mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lolArmed <= 1'b0;
    else if (!pllEngagedExt) lolArmed <= 1'b0;
    else if (pllLocked)      lolArmed <= 1'b1;
  end

  always_comb begin
    src.loc  = clkMonEn & locHit;
    src.lol  = lolResetEn & lolArmed & pllEngagedExt & ~pllLocked & ~inStop;
    src.sack = sackHit;
    src.sw   = swResetReq;
    anyReq   = |src;
    strb.src      = src;
    strb.loadHold = anyReq;
    strb.capture  = anyReq & ~sysReset;
    strb.dbgJoin  = src.loc | src.lol | src.sack;
  end
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
#(
  parameter int NUM_RANGES  = 2,
  parameter int NUM_ACK     = 4,
  parameter int ACK_TIMEOUT = 1025,
  parameter int HOLD_CYC    = 16,
  localparam int RSEL_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
  localparam int CNT_W  = $clog2(ACK_TIMEOUT + 1),
  localparam int HOLD_W = $clog2(HOLD_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [RSEL_W-1:0]     rangeSel,
  input  logic [NUM_RANGES-1:0] refSlow,
  input  logic [NUM_RANGES-1:0] refFast,
  input  logic                  stopReq,
  input  logic [NUM_ACK-1:0]    stopAck,
  input  logic                  lpoTick,
  input  ctlStrb_t              strb,
  output logic                  locHit,
  output logic                  sackHit,
  output logic                  sysReset,
  output logic                  dbgReset,
  output srcVec_t               flags
);
  // per-range two-stage synchronizers
  logic [NUM_RANGES-1:0] rngHit;
  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    logic [1:0] slowSh, fastSh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slowSh <= '0;
        fastSh <= '0;
      end else begin
        slowSh <= {slowSh[0], refSlow[r]};
        fastSh <= {fastSh[0], refFast[r]};
      end
    end
    assign rngHit[r] = slowSh[1] | fastSh[1];
  end
  assign locHit = rngHit[rangeSel];

  // stop acknowledge watchdog on slow tick edges
  logic             tickPrev;
  logic [CNT_W-1:0] tickCnt;
  logic             tickRise, cntClr;
  assign tickRise = lpoTick & ~tickPrev;
  assign cntClr   = ~stopReq | (&stopAck);
  assign sackHit  = tickRise & ~cntClr & (tickCnt == CNT_W'(ACK_TIMEOUT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickPrev <= 1'b0;
      tickCnt  <= '0;
    end else begin
      tickPrev <= lpoTick;
      if (cntClr)
        tickCnt <= '0;
      else if (tickRise && tickCnt != CNT_W'(ACK_TIMEOUT))
        tickCnt <= tickCnt + 1'b1;
    end
  end

  // reset stretch and cause capture
  logic [HOLD_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= HOLD_W'(HOLD_CYC);
      sysReset <= 1'b1;
      dbgReset <= 1'b1;
      flags    <= '0;
    end else if (strb.loadHold) begin
      holdCnt  <= HOLD_W'(HOLD_CYC);
      sysReset <= 1'b1;
      if (strb.capture) begin
        flags    <= strb.src;
        dbgReset <= strb.dbgJoin;
      end else begin
        dbgReset <= dbgReset | strb.dbgJoin;
      end
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
      if (holdCnt == HOLD_W'(1)) begin
        sysReset <= 1'b0;
        dbgReset <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int NUM_RANGES  = 2,
  parameter int NUM_ACK     = 4,
  parameter int ACK_TIMEOUT = 1025,
  parameter int HOLD_CYC    = 16,
  localparam int RSEL_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clkMonEn,
  input  logic [RSEL_W-1:0]     rangeSel,
  input  logic [NUM_RANGES-1:0] refSlow,
  input  logic [NUM_RANGES-1:0] refFast,
  input  logic                  pllEngagedExt,
  input  logic                  pllLocked,
  input  logic                  lolResetEn,
  input  logic                  inStop,
  input  logic                  stopReq,
  input  logic [NUM_ACK-1:0]    stopAck,
  input  logic                  lpoTick,
  input  logic                  swResetReq,
  output logic                  sysReset,
  output logic                  dbgReset,
  output logic                  locFlag,
  output logic                  lolFlag,
  output logic                  sackFlag,
  output logic                  swFlag
);
  ctlStrb_t strb;
  srcVec_t  flags;
  logic     locHit, sackHit;

  rst_cause_ctl ctl_i (
    .clk(clk), .rstN(rstN), .clkMonEn(clkMonEn), .pllEngagedExt(pllEngagedExt),
    .pllLocked(pllLocked), .lolResetEn(lolResetEn), .inStop(inStop),
    .swResetReq(swResetReq), .locHit(locHit), .sackHit(sackHit),
    .sysReset(sysReset), .strb(strb)
  );

  rst_cause_dp #(
    .NUM_RANGES(NUM_RANGES), .NUM_ACK(NUM_ACK),
    .ACK_TIMEOUT(ACK_TIMEOUT), .HOLD_CYC(HOLD_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .rangeSel(rangeSel), .refSlow(refSlow),
    .refFast(refFast), .stopReq(stopReq), .stopAck(stopAck), .lpoTick(lpoTick),
    .strb(strb), .locHit(locHit), .sackHit(sackHit), .sysReset(sysReset),
    .dbgReset(dbgReset), .flags(flags)
  );

  assign locFlag  = flags.loc;
  assign lolFlag  = flags.lol;
  assign sackFlag = flags.sack;
  assign swFlag   = flags.sw;
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk (
  input logic       clk,
  input logic       rstN,
  input logic       clkMonEn,
  input logic       inStop,
  input logic [3:0] reqVec,
  input logic       sysReset,
  input logic       dbgReset,
  input logic [3:0] flagVec
);
  // R1
  clk_mon_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkMonEn |-> !reqVec[0]);

  // R4
  stop_blocks_lol_chk: assert property (@(posedge clk) disable iff (!rstN)
    inStop |-> !reqVec[1]);

  // R8
  dbg_within_sys_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgReset |-> sysReset);

  // R9
  flag_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysReset) |-> flagVec == $past(reqVec));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysReset && $past(sysReset)) |-> $stable(flagVec));

  // R10
  req_starts_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|reqVec) |=> sysReset);
endmodule

bind rst_cause_ctrl rst_cause_chk chk_i (
  .clk(clk), .rstN(rstN), .clkMonEn(clkMonEn), .inStop(inStop),
  .reqVec(strb.src), .sysReset(sysReset), .dbgReset(dbgReset), .flagVec(flags)
);

// File: tb/rst_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb_top;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkMonEn = 1'b0;
  logic [0:0] rangeSel = '0;
  logic [1:0] refSlow = '0, refFast = '0;
  logic       pllEngagedExt = 1'b0, pllLocked = 1'b0, lolResetEn = 1'b0, inStop = 1'b0;
  logic       stopReq = 1'b0;
  logic [3:0] stopAck = '0;
  logic       lpoTick = 1'b0, swResetReq = 1'b0;
  logic       sysReset, dbgReset, locFlag, lolFlag, sackFlag, swFlag;

  always #5 clk = ~clk;

  rst_cause_ctrl dut_i (
    .clk(clk), .rstN(rstN), .clkMonEn(clkMonEn), .rangeSel(rangeSel),
    .refSlow(refSlow), .refFast(refFast), .pllEngagedExt(pllEngagedExt),
    .pllLocked(pllLocked), .lolResetEn(lolResetEn), .inStop(inStop),
    .stopReq(stopReq), .stopAck(stopAck), .lpoTick(lpoTick),
    .swResetReq(swResetReq), .sysReset(sysReset), .dbgReset(dbgReset),
    .locFlag(locFlag), .lolFlag(lolFlag), .sackFlag(sackFlag), .swFlag(swFlag)
  );

  int  nChk = 0, nFail = 0;
  bit  finished = 0;
  // expected episode: {dbg, sw, sack, lol, loc}
  logic [4:0] expQ[$];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(input logic dbg, input logic [3:0] f);
    expQ.push_back({dbg, f});
  endtask

  task automatic tickPulses(input int n);
    for (int i = 0; i < n; i++) begin
      lpoTick = 1'b1; @(negedge clk);
      lpoTick = 1'b0; @(negedge clk);
    end
  endtask

  // monitor: scoreboard of reset episodes
  bit         monOn = 0, prevRst = 0, epDbg = 0;
  logic [3:0] epFlags;
  int         epLen = 0;
  always @(negedge clk) begin
    if (monOn) begin
      if (sysReset && !prevRst) begin
        epFlags = {swFlag, sackFlag, lolFlag, locFlag};
        epDbg   = dbgReset;
        epLen   = 1;
      end else if (sysReset) begin
        epLen++;
        epDbg = epDbg | dbgReset;
      end else if (prevRst) begin
        if (expQ.size() == 0) begin
          nChk++; nFail++;
          $display("FAIL R9 unexpected reset act=%b exp=none", epFlags);
        end else begin
          logic [4:0] e;
          e = expQ.pop_front();
          check("R9 cause flags", {4'b0, epFlags}, {4'b0, e[3:0]});
          check("R7/R8 debug reset", {7'b0, epDbg}, {7'b0, e[4]});
          check("R10 hold length", 8'(epLen), 8'(HOLD));
        end
      end
      prevRst = sysReset;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R11 power-on
    idle(3);
    check("R11 sys in por", {7'b0, sysReset}, 8'd1);
    check("R11 dbg in por", {7'b0, dbgReset}, 8'd1);
    check("R11 flags in por", {4'b0, swFlag, sackFlag, lolFlag, locFlag}, 8'd0);
    rstN = 1'b1;
    idle(15);
    check("R11 still held", {7'b0, sysReset}, 8'd1);
    idle(1);
    check("R11 released", {6'b0, sysReset, dbgReset}, 8'd0);
    monOn = 1;

    // R1 monitor disabled
    refSlow[0] = 1'b1; idle(1); refSlow[0] = 1'b0; idle(25);
    check("R1 disabled monitor", {7'b0, sysReset}, 8'd0);

    // R1 enabled, range 0 fast limit
    clkMonEn = 1'b1;
    pushExp(1'b1, 4'b0001);
    refFast[0] = 1'b1; idle(1); refFast[0] = 1'b0;
    idle(1);
    check("R1 not yet at edge n+1", {7'b0, sysReset}, 8'd0);
    idle(1);
    check("R1 reset at edge n+2", {7'b0, sysReset}, 8'd1);
    idle(25);
    check("R9 flag kept after release", {4'b0, swFlag, sackFlag, lolFlag, locFlag}, 8'h01);

    // R2 unselected range ignored, then selected
    refSlow[1] = 1'b1; idle(1); refSlow[1] = 1'b0; idle(25);
    check("R2 other range ignored", {7'b0, sysReset}, 8'd0);
    rangeSel = 1'b1;
    pushExp(1'b1, 4'b0001);
    refSlow[1] = 1'b1; idle(1); refSlow[1] = 1'b0; idle(25);
    refFast[0] = 1'b1; idle(1); refFast[0] = 1'b0; idle(25);
    check("R2 range 0 ignored when 1 chosen", {7'b0, sysReset}, 8'd0);

    // R3 arming rules
    lolResetEn = 1'b1;
    idle(5);
    check("R3 no arm outside engaged mode", {7'b0, sysReset}, 8'd0);
    pllEngagedExt = 1'b1; idle(10);
    check("R3 no arm before lock", {7'b0, sysReset}, 8'd0);
    pllLocked = 1'b1; idle(3);
    lolResetEn = 1'b0;
    pllLocked = 1'b0; idle(1); pllLocked = 1'b1; idle(25);
    check("R3 enable off", {7'b0, sysReset}, 8'd0);
    // R4 stop blocks lock loss
    lolResetEn = 1'b1; inStop = 1'b1;
    pllLocked = 1'b0; idle(1); pllLocked = 1'b1; idle(25);
    check("R4 in stop", {7'b0, sysReset}, 8'd0);
    inStop = 1'b0; idle(2);
    pushExp(1'b1, 4'b0010);
    pllLocked = 1'b0; idle(1); pllLocked = 1'b1; idle(25);
    // R3 leaving engaged mode disarms
    pllEngagedExt = 1'b0; idle(2);
    pllEngagedExt = 1'b1; pllLocked = 1'b0; idle(25);
    check("R3 disarmed after mode exit", {7'b0, sysReset}, 8'd0);
    pllEngagedExt = 1'b0; lolResetEn = 1'b0;

    // R7 software reset spares debug; R9 old cause cleared
    pushExp(1'b0, 4'b1000);
    swResetReq = 1'b1; idle(1); swResetReq = 1'b0; idle(25);

    // R9 two causes in one cycle
    rangeSel = 1'b0;
    pushExp(1'b1, 4'b1001);
    refSlow[0] = 1'b1; idle(1); refSlow[0] = 1'b0;
    idle(1);
    swResetReq = 1'b1; idle(1); swResetReq = 1'b0;
    idle(25);

    // R5 timeout on 1025th tick edge only
    stopReq = 1'b1;
    tickPulses(1024);
    idle(3);
    check("R5 no reset at 1024 ticks", {7'b0, sysReset}, 8'd0);
    pushExp(1'b1, 4'b0100);
    tickPulses(1);
    idle(25);
    stopReq = 1'b0; idle(2);

    // R6 count restarts on full acknowledge and on request drop
    stopReq = 1'b1;
    tickPulses(1000);
    stopAck = '1; tickPulses(5); stopAck = '0;
    tickPulses(1000);
    check("R6 cleared by acknowledge", {7'b0, sysReset}, 8'd0);
    stopReq = 1'b0; idle(2); stopReq = 1'b1;
    tickPulses(1000);
    // R6 level held high for many cycles counts once
    lpoTick = 1'b1; idle(40); lpoTick = 1'b0; idle(2);
    tickPulses(23);
    check("R6 cleared by request drop", {7'b0, sysReset}, 8'd0);
    stopReq = 1'b0;
    idle(25);

    check("R10 all episodes seen", 8'(expQ.size()), 8'd0);
    finished = 1;
    summary();
    $finish;
  end
endmodule